// File: doc/BRIEF.md
# Accumulator Node Control Unit

This block is the sequencing core of a very small accumulator processor. A program of up to fifteen 18-bit words is pushed in through a load stream. The number of words accepted also serves as the program length. Once loading stops, the unit fetches the word at the program counter and decodes it. It executes the word against an 11-bit signed accumulator and a hidden backup register, then moves the counter on. The counter never leaves the loaded program: sequential flow wraps to index 0, and jump targets are clamped into range.

Any operand or destination that names a neighbour port becomes a request on an external port interface, which is a valid/ready pair. The request holds steady, and the whole processor stalls, until the port side answers with ready. Arithmetic on the accumulator saturates at plus or minus 999 and is done in the same cycle as the instruction.

The load stream follows valid/ready rules. A word is taken on a rising edge where `ld_valid` and `ld_ready` are both high. `ld_ready` falls once fifteen words are stored, and only reset restarts the load count. Words offered while `ld_ready` is low are dropped. The port side applies back-pressure by holding `pt_ready` low. The unit keeps its request, port select, direction and write data unchanged until a cycle in which `pt_ready` is high.

Top module: `acc_node_ctrl`

## Requirements
- R1: An instruction word is {opcode[17:14], source[13:3], destination[2:0]}. The opcodes are NOP=0, MOV=1, SWP=2, SAV=3, ADD=4, SUB=5, NEG=6, JMP=7, JEZ=8, JNZ=9, JGZ=10, JLZ=11 and JRO=12, and codes 13 to 15 act as NOP. A source field from 0x400 to 0x40F is a target code k = field-0x400, and any other value is an 11-bit two's complement literal. Codes k and the destination field share one numbering: 0 accumulator, 1 null sink, 2 up, 3 down, 4 left, 5 right, 6 any, 7 last. Source codes 8 to 15 read as 0.
- R2: A load word is stored at index N on an edge with `ld_valid` and `ld_ready` both high, and N then increments. `ld_ready` is high exactly while N < 15. N is the program length, and reset sets it to 0.
- R3: On any cycle with `ld_valid` high, no instruction executes and `pt_req` is low. The program counter is 0 after that edge, so execution resumes at index 0. With a program length of 0, nothing executes.
- R4: MOV into the accumulator, ADD, SUB and NEG write their result to the accumulator, limited to the range -999 to 999.
- R5: Reading the null sink gives 0, and writing to it changes nothing and issues no port request. The accumulator code reads the accumulator. SWP exchanges the accumulator with the backup register, and SAV copies the accumulator into it.
- R6: JEZ, JNZ, JGZ and JLZ are taken when the accumulator is zero, nonzero, above zero or below zero respectively. JMP and JRO are always taken.
- R7: A taken jump goes to the operand value, or for JRO to PC plus the operand value. Any target below 0 becomes 0, and any target beyond the last loaded index becomes that index.
- R8: A completed instruction that is not a taken jump advances the PC by one. After the last loaded index, the PC goes to 0.
- R9: While `pt_req` is high and `pt_ready` is low, the unit holds `pt_req`, `pt_sel`, `pt_write`, `pt_wdata`, the PC and the accumulator. A read uses `pt_write`=0 and selects the source code, and a write uses `pt_write`=1 and selects the destination field.
- R10: An instruction with no port operand completes in one cycle. A port read or write completes in the cycle that `pt_ready` is high. A MOV from a port to a port first completes its read, then the write with the data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Load word offered; also holds execution |
| ld_ready | output | 1 | Program memory has a free slot |
| ld_word | input | 18 | Instruction word to store |
| pt_req | output | 1 | Port transfer requested |
| pt_write | output | 1 | 1 = write to port, 0 = read from port |
| pt_sel | output | 3 | Port code (2 to 7) of the transfer |
| pt_wdata | output | 11 | Data for a port write |
| pt_ready | input | 1 | Port side completes the transfer this cycle |
| pt_rdata | input | 11 | Data returned for a port read |
| acc_o | output | 11 | Accumulator value |
| pc_o | output | 4 | Program counter |

## Verification
State changes are due one rising edge after the cycle that causes them. Each accepted load word, executed instruction or completed port handshake therefore shows up on `acc_o`, `pc_o` and `ld_ready` at the next falling edge. `pt_req`, `pt_sel`, `pt_write` and `pt_wdata` follow the current PC and handshake state in the same cycle, with no delay. The bench steps a behavioural model at each rising edge, using the inputs that were held through that cycle. It compares every output at the following falling edge, before it drives new inputs. Directed checks at fixed cycle counts after loading pin down saturation, jump clamping, stalls and wrap-around.

// File: rtl/acc_node_pkg.sv
package acc_node_pkg;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_MOV = 4'd1,
    OP_SWP = 4'd2,
    OP_SAV = 4'd3,
    OP_ADD = 4'd4,
    OP_SUB = 4'd5,
    OP_NEG = 4'd6,
    OP_JMP = 4'd7,
    OP_JEZ = 4'd8,
    OP_JNZ = 4'd9,
    OP_JGZ = 4'd10,
    OP_JLZ = 4'd11,
    OP_JRO = 4'd12
  } op_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_NEG  = 2'd3
  } alu_fn_e;

  // target numbering shared by source codes and destination field
  localparam int unsigned TGT_ACC        = 0;
  localparam int unsigned TGT_NIL        = 1;
  localparam int unsigned TGT_FIRST_PORT = 2;
  localparam int unsigned CODE_W         = 4;

endpackage

// File: rtl/acc_node_pmem.sv
module acc_node_pmem #(
  parameter int DEPTH  = 15,
  parameter int WORD_W = 18,
  parameter int AW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [WORD_W-1:0] ld_word,
  output logic              ld_ready,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word,
  output logic [AW-1:0]     prog_len
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     cnt_q;

  assign ld_ready = (cnt_q < AW'(DEPTH));
  assign prog_len = cnt_q;
  assign rd_word  = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_valid && ld_ready) begin
      cnt_q <= cnt_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) begin
      mem[cnt_q] <= ld_word;
    end
  end

  // R2: length only moves on an accepted word, and never passes the depth
  p_len_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(ld_valid && ld_ready) |=> $stable(cnt_q));
  p_len_cap_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= AW'(DEPTH));

endmodule

// File: rtl/acc_node_alu.sv
module acc_node_alu
  import acc_node_pkg::*;
#(
  parameter int DW  = 11,
  parameter int SAT = 999
) (
  input  alu_fn_e              fn,
  input  logic signed [DW-1:0] acc,
  input  logic signed [DW-1:0] opnd,
  output logic signed [DW-1:0] res
);

  localparam int EW = DW + 2;
  localparam logic signed [EW-1:0] HI = EW'(SAT);
  localparam logic signed [EW-1:0] LO = -HI;

  logic signed [EW-1:0] wide;

  always_comb begin
    unique case (fn)
      ALU_ADD: wide = EW'(acc) + EW'(opnd);
      ALU_SUB: wide = EW'(acc) - EW'(opnd);
      ALU_NEG: wide = -EW'(acc);
      default: wide = EW'(opnd);
    endcase
    if (wide > HI)      res = HI[DW-1:0];
    else if (wide < LO) res = LO[DW-1:0];
    else                res = wide[DW-1:0];
  end

endmodule

// File: rtl/acc_node_pcu.sv
module acc_node_pcu #(
  parameter int AW = 4,
  parameter int DW = 11
) (
  input  logic [AW-1:0]        pc,
  input  logic [AW-1:0]        len,
  input  logic                 take,
  input  logic                 rel,
  input  logic signed [DW-1:0] opnd,
  output logic [AW-1:0]        pc_next
);

  localparam int EW = ((DW > AW) ? DW : AW) + 2;

  logic signed [EW-1:0] base;
  logic signed [EW-1:0] tgt;
  logic signed [EW-1:0] last;
  logic [AW:0]          inc;

  always_comb begin
    inc  = {1'b0, pc} + (AW+1)'(1);
    base = rel ? EW'($signed({1'b0, pc})) : '0;
    tgt  = base + EW'(opnd);
    last = EW'($signed({1'b0, len})) - EW'(1);
    if (take) begin
      if (tgt < 0)         pc_next = '0;
      else if (tgt > last) pc_next = last[AW-1:0];
      else                 pc_next = tgt[AW-1:0];
    end else if (inc >= {1'b0, len}) begin
      pc_next = '0;
    end else begin
      pc_next = inc[AW-1:0];
    end
  end

endmodule

// File: rtl/acc_node_ctrl.sv
module acc_node_ctrl
  import acc_node_pkg::*;
#(
  parameter int DATA_W  = 11,
  parameter int SEL_W   = 3,
  parameter int DEPTH   = 15,
  parameter int SAT_MAX = 999,
  localparam int OP_W   = $bits(op_e),
  localparam int WORD_W = OP_W + DATA_W + SEL_W,
  localparam int AW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [WORD_W-1:0] ld_word,
  output logic              pt_req,
  output logic              pt_write,
  output logic [SEL_W-1:0]  pt_sel,
  output logic [DATA_W-1:0] pt_wdata,
  input  logic              pt_ready,
  input  logic [DATA_W-1:0] pt_rdata,
  output logic [DATA_W-1:0] acc_o,
  output logic [AW-1:0]     pc_o
);

  localparam logic [DATA_W-CODE_W-1:0] CODE_TAG =
    {1'b1, {(DATA_W-CODE_W-1){1'b0}}};

  logic [AW-1:0]     pc_q, pc_nxt, len;
  logic [WORD_W-1:0] word;
  logic signed [DATA_W-1:0] acc_q, bak_q, src_val_q;
  logic signed [DATA_W-1:0] opnd, alu_res, acc_nxt, bak_nxt;
  logic              have_src_q;

  op_e               op;
  logic [DATA_W-1:0] src_f;
  logic [SEL_W-1:0]  dst_f;
  logic [CODE_W-1:0] code;
  logic              is_code, src_port, dst_port, uses_src;
  logic              running, need_rd, need_wr, latch_rd, retire;
  logic              take, rel;
  alu_fn_e           fn;

  acc_node_pmem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_pmem (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_word(ld_word),
    .ld_ready(ld_ready), .rd_addr(pc_q), .rd_word(word), .prog_len(len)
  );

  // field split
  always_comb begin
    op       = op_e'(word[WORD_W-1 -: OP_W]);
    src_f    = word[SEL_W +: DATA_W];
    dst_f    = word[SEL_W-1:0];
    code     = src_f[CODE_W-1:0];
    is_code  = (src_f[DATA_W-1:CODE_W] == CODE_TAG);
    src_port = is_code && (code >= CODE_W'(TGT_FIRST_PORT))
                       && (code < CODE_W'(1 << SEL_W));
    dst_port = (dst_f >= SEL_W'(TGT_FIRST_PORT));
    unique case (op)
      OP_MOV, OP_ADD, OP_SUB, OP_JMP, OP_JEZ, OP_JNZ,
      OP_JGZ, OP_JLZ, OP_JRO: uses_src = 1'b1;
      default:                uses_src = 1'b0;
    endcase
  end

  // operand resolution: latched read, live port data, register or literal
  always_comb begin
    if (have_src_q)                     opnd = src_val_q;
    else if (src_port)                  opnd = $signed(pt_rdata);
    else if (is_code && code == CODE_W'(TGT_ACC)) opnd = acc_q;
    else if (is_code)                   opnd = '0;
    else                                opnd = $signed(src_f);
  end

  // port handshake and completion
  always_comb begin
    running  = !ld_valid && (len != '0);
    need_rd  = running && uses_src && src_port && !have_src_q;
    need_wr  = running && (op == OP_MOV) && dst_port;
    pt_req   = need_rd || need_wr;
    pt_write = !need_rd;
    pt_sel   = need_rd ? code[SEL_W-1:0] : dst_f;
    pt_wdata = opnd;
    latch_rd = need_rd && need_wr && pt_ready;
    retire   = running && (need_rd ? (pt_ready && !need_wr)
                                   : (!need_wr || pt_ready));
  end

  // branch condition
  always_comb begin
    rel = (op == OP_JRO);
    unique case (op)
      OP_JMP, OP_JRO: take = 1'b1;
      OP_JEZ:         take = (acc_q == '0);
      OP_JNZ:         take = (acc_q != '0);
      OP_JGZ:         take = (acc_q > 0);
      OP_JLZ:         take = (acc_q < 0);
      default:        take = 1'b0;
    endcase
  end

  acc_node_pcu #(.AW(AW), .DW(DATA_W)) u_pcu (
    .pc(pc_q), .len(len), .take(take), .rel(rel), .opnd(opnd), .pc_next(pc_nxt)
  );

  always_comb begin
    unique case (op)
      OP_ADD:  fn = ALU_ADD;
      OP_SUB:  fn = ALU_SUB;
      OP_NEG:  fn = ALU_NEG;
      default: fn = ALU_PASS;
    endcase
  end

  acc_node_alu #(.DW(DATA_W), .SAT(SAT_MAX)) u_alu (
    .fn(fn), .acc(acc_q), .opnd(opnd), .res(alu_res)
  );

  always_comb begin
    acc_nxt = acc_q;
    bak_nxt = bak_q;
    unique case (op)
      OP_MOV:                 if (dst_f == SEL_W'(TGT_ACC)) acc_nxt = alu_res;
      OP_ADD, OP_SUB, OP_NEG: acc_nxt = alu_res;
      OP_SWP:                 begin acc_nxt = bak_q; bak_nxt = acc_q; end
      OP_SAV:                 bak_nxt = acc_q;
      default:                ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      acc_q      <= '0;
      bak_q      <= '0;
      src_val_q  <= '0;
      have_src_q <= 1'b0;
    end else if (ld_valid) begin
      pc_q       <= '0;
      have_src_q <= 1'b0;
    end else if (latch_rd) begin
      src_val_q  <= $signed(pt_rdata);
      have_src_q <= 1'b1;
    end else if (retire) begin
      pc_q       <= pc_nxt;
      acc_q      <= acc_nxt;
      bak_q      <= bak_nxt;
      have_src_q <= 1'b0;
    end
  end

  assign acc_o = acc_q;
  assign pc_o  = pc_q;

  // R4: accumulator never leaves the saturation window
  p_acc_range_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= DATA_W'(SAT_MAX)) && (acc_q >= -DATA_W'(SAT_MAX)));

  // R8: PC stays inside the loaded program
  p_pc_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_q == '0) || (pc_q < len));

  // R3: loading suppresses port traffic and parks the PC at 0
  p_load_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> !pt_req);
  p_load_park_r3: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> (pc_q == '0));

  // R9: an unanswered request is held and the core stalls
  p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pt_req && !pt_ready && !ld_valid) |=> ld_valid ||
      (pt_req && $stable(pt_sel) && $stable(pt_write) &&
       $stable(pc_q) && $stable(acc_q)));
  p_wdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (pt_req && pt_write && !pt_ready && !ld_valid) |=> ld_valid ||
      $stable(pt_wdata));

endmodule

// File: tb/tb_acc_node_ctrl.sv
module tb_acc_node_ctrl;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_valid;
  logic        ld_ready;
  logic [17:0] ld_word;
  logic        pt_req, pt_write, pt_ready;
  logic [2:0]  pt_sel;
  logic [10:0] pt_wdata, pt_rdata, acc_o;
  logic [3:0]  pc_o;

  int checks = 0;
  int fails  = 0;

  // reference model state
  int m_acc, m_bak, m_pc, m_len, m_hold;
  bit m_have;
  int prog [15];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  acc_node_ctrl dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_word(ld_word), .pt_req(pt_req), .pt_write(pt_write), .pt_sel(pt_sel),
    .pt_wdata(pt_wdata), .pt_ready(pt_ready), .pt_rdata(pt_rdata),
    .acc_o(acc_o), .pc_o(pc_o)
  );

  function automatic int enc(int op, int src, int dst);
    return (op << 14) | ((src & 2047) << 3) | (dst & 7);
  endfunction

  function automatic int s11(int v);
    v = v & 2047;
    return (v >= 1024) ? v - 2048 : v;
  endfunction

  function automatic int sat(int v);
    if (v > 999) return 999;
    if (v < -999) return -999;
    return v;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // decoded view of the current model instruction
  int d_op, d_src, d_dst, d_code;
  bit d_iscode, d_srcport, d_uses, e_rd, e_wr;

  function automatic void decode();
    int w;
    w = (m_len > 0) ? prog[m_pc] : 0;
    d_op = (w >> 14) & 15;
    d_src = (w >> 3) & 2047;
    d_dst = w & 7;
    d_iscode = (d_src >= 1024) && (d_src < 1040);
    d_code = d_src - 1024;
    d_srcport = d_iscode && d_code >= 2 && d_code <= 7;
    d_uses = (d_op == 1) || (d_op == 4) || (d_op == 5) || (d_op >= 7 && d_op <= 12);
    e_rd = !ld_valid && m_len > 0 && d_uses && d_srcport && !m_have;
    e_wr = !ld_valid && m_len > 0 && d_op == 1 && d_dst >= 2;
  endfunction

  function automatic int operand();
    if (m_have) return m_hold;
    if (d_srcport) return s11(pt_rdata);
    if (d_iscode) return (d_code == 0) ? m_acc : 0;
    return s11(d_src);
  endfunction

  function automatic void model_update();
    int o, t;
    bit tk;
    if (rst) begin
      m_acc = 0; m_bak = 0; m_pc = 0; m_len = 0; m_have = 0; m_hold = 0;
      return;
    end
    decode();
    if (ld_valid) begin
      if (m_len < 15) begin prog[m_len] = int'(ld_word); m_len++; end
      m_pc = 0; m_have = 0;
      return;
    end
    if (m_len == 0) return;
    if (e_rd && !pt_ready) return;
    if (e_rd && e_wr) begin m_have = 1; m_hold = s11(pt_rdata); return; end
    if (e_wr && !pt_ready) return;
    o = operand();
    m_have = 0;
    tk = 0;
    case (d_op)
      1: if (d_dst == 0) m_acc = sat(o);
      2: begin t = m_acc; m_acc = m_bak; m_bak = t; end
      3: m_bak = m_acc;
      4: m_acc = sat(m_acc + o);
      5: m_acc = sat(m_acc - o);
      6: m_acc = -m_acc;
      7, 12: tk = 1;
      8: tk = (m_acc == 0);
      9: tk = (m_acc != 0);
      10: tk = (m_acc > 0);
      11: tk = (m_acc < 0);
      default: ;
    endcase
    if (tk) begin
      t = (d_op == 12) ? m_pc + o : o;
      if (t < 0) t = 0;
      if (t > m_len - 1) t = m_len - 1;
      m_pc = t;
    end else begin
      m_pc = (m_pc + 1 >= m_len) ? 0 : m_pc + 1;
    end
  endfunction

  task automatic compare_all();
    decode();
    check(s11(acc_o) == m_acc, "R4 acc", s11(acc_o), m_acc);
    check(int'(pc_o) == m_pc, "R8 pc", pc_o, m_pc);
    check(ld_ready == (m_len < 15), "R2 ld_ready", ld_ready, m_len < 15);
    check(pt_req == (e_rd || e_wr), "R9 pt_req", pt_req, e_rd || e_wr);
    if (pt_req && (e_rd || e_wr)) begin
      check(pt_write == !e_rd, "R9 pt_write", pt_write, !e_rd);
      check(int'(pt_sel) == (e_rd ? d_code : d_dst), "R9 pt_sel", pt_sel,
            e_rd ? d_code : d_dst);
      if (!e_rd)
        check(s11(pt_wdata) == operand(), "R9 pt_wdata", s11(pt_wdata), operand());
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst = 1'b1; ld_valid = 1'b0;
    run(2);
    rst = 1'b0;
  endtask

  task automatic load(int words[$]);
    foreach (words[i]) begin
      ld_valid = 1'b1;
      ld_word = 18'(words[i]);
      step();
    end
    ld_valid = 1'b0;
  endtask

  task automatic run_random(int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      pt_ready = seed[20];
      pt_rdata = 11'(int'(seed[30:16] % 1999) - 999);
      step();
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_valid = 1'b0; ld_word = '0; pt_ready = 1'b0; pt_rdata = '0;
    @(negedge clk);
    do_reset();
    // R2 R3: reset state
    check(ld_ready == 1'b1, "R2 reset ld_ready", ld_ready, 1);
    check(pc_o == 4'd0 && acc_o == 11'd0, "R3 reset pc/acc", pc_o, 0);
    check(pt_req == 1'b0, "R3 idle no request", pt_req, 0);

    // program A: arithmetic, NIL, SWP/SAV
    load('{enc(1, 995, 0), enc(4, 10, 0), enc(3, 0, 0), enc(6, 0, 0),
           enc(5, 5, 0), enc(4, 1025, 0), enc(1, 1024, 1), enc(2, 0, 0)});
    run(1);
    check(s11(acc_o) == 995, "R1 literal decode", s11(acc_o), 995);
    run(1);
    check(s11(acc_o) == 999, "R4 upper saturation", s11(acc_o), 999);
    run(2);
    check(s11(acc_o) == -999, "R4 negate", s11(acc_o), -999);
    run(3);
    check(s11(acc_o) == -999 && pt_req == 1'b0, "R5 NIL read/write", s11(acc_o), -999);
    check(pc_o == 4'd7, "R10 one cycle each", pc_o, 7);
    run(1);
    check(s11(acc_o) == 999, "R5 SWP restores saved", s11(acc_o), 999);
    check(pc_o == 4'd0, "R8 wrap to 0", pc_o, 0);
    ld_valid = 1'b1; ld_word = 18'(enc(0, 0, 0));
    step();
    ld_valid = 1'b0;
    check(pc_o == 4'd0 && s11(acc_o) == 999, "R3 load holds execution", s11(acc_o), 999);
    run(1);
    check(pc_o == 4'd1 && s11(acc_o) == 995, "R3 restart at 0", pc_o, 1);
    run(20);

    // program B: port traffic
    do_reset();
    load('{enc(1, 1026, 0), enc(4, 1028, 0), enc(1, 1024, 3), enc(1, 1029, 6)});
    pt_ready = 1'b0;
    run(5);
    check(pt_req && !pt_write && pt_sel == 3'd2 && pc_o == 4'd0,
          "R9 stalled read held", pt_sel, 2);
    pt_ready = 1'b1; pt_rdata = 11'd300;
    run(1);
    check(s11(acc_o) == 300 && pc_o == 4'd1, "R10 read completes on ready", s11(acc_o), 300);
    pt_ready = 1'b0;
    run(1);
    check(pt_req && pt_sel == 3'd4, "R9 left read request", pt_sel, 4);
    run_random(120);

    // program C: jumps and clamping
    do_reset();
    pt_ready = 1'b0;
    load('{enc(8, 2, 0), enc(7, 6, 0), enc(4, 5, 0), enc(10, 5, 0), enc(0, 0, 0),
           enc(9, 30, 0), enc(12, 1, 0), enc(6, 0, 0), enc(11, 0, 0), enc(12, -20, 0)});
    run(1);
    check(pc_o == 4'd2, "R6 JEZ taken on zero", pc_o, 2);
    run(3);
    check(pc_o == 4'd9, "R7 high clamp", pc_o, 9);
    run(1);
    check(pc_o == 4'd0, "R7 low clamp of JRO", pc_o, 0);
    run(40);

    // program D: full memory, overflow word dropped
    do_reset();
    begin
      int w[$];
      for (int i = 0; i < 15; i++) w.push_back(enc(4, 1, 0));
      load(w);
    end
    check(ld_ready == 1'b0, "R2 full after 15", ld_ready, 0);
    ld_valid = 1'b1; ld_word = 18'(enc(1, 500, 0));
    step();
    ld_valid = 1'b0;
    check(ld_ready == 1'b0 && pc_o == 4'd0, "R2 extra word refused", ld_ready, 0);
    run(15);
    check(s11(acc_o) == 15 && pc_o == 4'd0, "R2 length is 15", s11(acc_o), 15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule